// File: doc/BRIEF.md
# Load/Store-Multiple Address Sequencer

This block turns a block-transfer request into a stream of word accesses. A request carries a register mask of `NREG` bits, a base address, one of four addressing modes, a direction flag, a privilege flag (S) and a writeback flag (W). The block counts the set bits of the mask and works out the lowest address the transfer touches. It then offers one access per cycle: a word address and the register index to move. The indices are visited in ascending order, and the address climbs by one word after each accepted access.

The memory and the register file sit outside the block. The outside logic takes an access by raising `ready_i` while `req_o` is high. When the last access is taken, the block pulses `done_o` for one cycle. With that pulse it presents the new base value and, when W was set, a writeback enable. The direction flag and a user-bank select are held on outputs for the whole operation. On a load that has S set and the highest register in the mask, a status-restore request is raised with the done pulse.

Top module: `lsm_addr_seq`

## Requirements
- R1: After reset `busy_o`, `req_o`, `done_o`, `wb_en_o` and `status_restore_o` are all low.
- R2: Mode 0 (increment, transfer then step) issues its first access at the base address.
- R3: Mode 1 (increment, step then transfer) issues its first access at base + 4.
- R4: Mode 2 (decrement, transfer then step) issues its first access at base − 4·n + 4, where n is the number of set mask bits.
- R5: Mode 3 (decrement, step then transfer) issues its first access at base − 4·n.
- R6: Accesses present the set mask bits from index 0 upward. The address rises by 4 after each accepted access. While `req_o` is high and `ready_i` is low, the address and the index are held.
- R7: Exactly n accesses are issued. `done_o` is high for exactly one cycle: the cycle after the last access is accepted. The block is idle (`busy_o` low) the cycle after that.
- R8: During the done cycle `wb_value_o` equals base + 4·n for modes 0 and 1, and base − 4·n for modes 2 and 3, modulo 2^ADDR_W. `wb_en_o` is high in that cycle only when W was set.
- R9: An empty mask produces `done_o` in the cycle after the start, and no access is issued.
- R10: `status_restore_o` is high in the done cycle exactly when the operation is a load (`load_i`=1) with S set and mask bit NREG−1 set. At all other times it is low.
- R11: While busy, `load_o` repeats the captured direction. `user_bank_o` is high when S is set and the operation is not a load that includes mask bit NREG−1.
- R12: `start_i` has no effect while `busy_o` is high, including during the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an operation (taken only when idle) |
| mask_i | input | NREG | Register mask |
| base_i | input | ADDR_W | Base address |
| mode_i | input | 2 | Addressing mode 0..3 |
| load_i | input | 1 | 1 = load, 0 = store |
| sbit_i | input | 1 | Privilege flag S |
| wback_i | input | 1 | Writeback flag W |
| ready_i | input | 1 | Outside logic accepts the current access |
| busy_o | output | 1 | An operation is in progress |
| req_o | output | 1 | An access is offered |
| req_addr_o | output | ADDR_W | Word address of the offered access |
| req_idx_o | output | IDX_W | Register index of the offered access |
| load_o | output | 1 | Captured direction |
| user_bank_o | output | 1 | Transfers use the user register bank |
| done_o | output | 1 | One-cycle completion pulse |
| wb_en_o | output | 1 | Base writeback enable (with done) |
| wb_value_o | output | ADDR_W | Written-back base value |
| status_restore_o | output | 1 | Status-restore request (with done) |

## Verification
On every cycle, the assertions check the stepping of the address and the index after each accepted access. They also check that both stay held during a stall, and that the done pulse comes right after the last acceptance and lasts one cycle. They further check that writeback and status-restore only appear with done, and that a start on an empty mask yields done without any access. The first address of each mode, the writeback value against the population count, and the full ascending order of the indices can only be seen in the bench's sweep. The same holds for the absence of any effect from a start raised while busy. The sweep covers many masks across all four modes, with stalls interleaved.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  typedef enum logic [1:0] {
    LSM_INC_AFTER  = 2'd0,
    LSM_INC_BEFORE = 2'd1,
    LSM_DEC_AFTER  = 2'd2,
    LSM_DEC_BEFORE = 2'd3
  } lsm_mode_e;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_RUN    = 2'd1,
    SEQ_FINISH = 2'd2
  } seq_state_e;
endpackage

// File: rtl/lsm_popcount.sv
module lsm_popcount #(
  parameter int N  = 16,
  parameter int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  mask,
  output logic [CW-1:0] count
);
  function automatic logic [CW-1:0] ones_in(input logic [N-1:0] m);
    logic [CW-1:0] acc;
    acc = '0;
    for (int i = 0; i < N; i++) acc = acc + CW'(m[i]);
    return acc;
  endfunction

  assign count = ones_in(mask);
endmodule

// File: rtl/lsm_lowest_pick.sv
module lsm_lowest_pick #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  remain,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] idx,
  output logic          any,
  output logic          single
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar g = 0; g < N; g++) begin : g_chain
    assign grant[g]  = remain[g] & ~seen[g];
    assign seen[g+1] = seen[g] | remain[g];
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++)
      if (grant[i]) idx = idx | IW'(i);
  end

  assign any    = seen[N];
  assign single = any && ((remain & ~grant) == '0);
endmodule

// File: rtl/lsm_addr_calc.sv
module lsm_addr_calc
  import lsm_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 5,
  parameter int WB = 4
) (
  input  logic [AW-1:0] base,
  input  lsm_mode_e     mode,
  input  logic [CW-1:0] cnt,
  output logic [AW-1:0] first_addr,
  output logic [AW-1:0] wb_value
);
  function automatic logic [AW-1:0] span_of(input logic [CW-1:0] c);
    return AW'(c) * AW'(WB);
  endfunction

  function automatic logic [AW-1:0] first_of(input logic [AW-1:0] b, input lsm_mode_e m,
                                             input logic [CW-1:0] c);
    case (m)
      LSM_INC_AFTER:  return b;
      LSM_INC_BEFORE: return b + AW'(WB);
      LSM_DEC_AFTER:  return b - span_of(c) + AW'(WB);
      default:        return b - span_of(c);
    endcase
  endfunction

  function automatic logic [AW-1:0] final_of(input logic [AW-1:0] b, input lsm_mode_e m,
                                             input logic [CW-1:0] c);
    if (m == LSM_INC_AFTER || m == LSM_INC_BEFORE) return b + span_of(c);
    return b - span_of(c);
  endfunction

  assign first_addr = first_of(base, mode, cnt);
  assign wb_value   = final_of(base, mode, cnt);
endmodule

// File: rtl/lsm_addr_seq.sv
module lsm_addr_seq
  import lsm_pkg::*;
#(
  parameter int NREG       = 16,
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4,
  parameter int IDX_W      = $clog2(NREG),
  localparam int CNT_W     = $clog2(NREG + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [NREG-1:0]   mask_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [1:0]        mode_i,
  input  logic              load_i,
  input  logic              sbit_i,
  input  logic              wback_i,
  input  logic              ready_i,
  output logic              busy_o,
  output logic              req_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [IDX_W-1:0]  req_idx_o,
  output logic              load_o,
  output logic              user_bank_o,
  output logic              done_o,
  output logic              wb_en_o,
  output logic [ADDR_W-1:0] wb_value_o,
  output logic              status_restore_o
);
  seq_state_e        state_q;
  logic [NREG-1:0]   remain_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] wbv_q;
  logic              load_q, user_q, wen_q, restore_q;

  logic [CNT_W-1:0]  mask_cnt;
  logic [ADDR_W-1:0] first_addr, final_base;
  logic [NREG-1:0]   grant;
  logic [IDX_W-1:0]  pick_idx;
  logic              pick_any, pick_single;

  // named internal events
  logic start_ok, accept, last_accept, mask_empty;

  lsm_popcount #(.N(NREG), .CW(CNT_W)) u_cnt (.mask(mask_i), .count(mask_cnt));

  lsm_addr_calc #(.AW(ADDR_W), .CW(CNT_W), .WB(WORD_BYTES)) u_calc (
    .base(base_i), .mode(lsm_mode_e'(mode_i)), .cnt(mask_cnt),
    .first_addr(first_addr), .wb_value(final_base)
  );

  lsm_lowest_pick #(.N(NREG), .IW(IDX_W)) u_pick (
    .remain(remain_q), .grant(grant), .idx(pick_idx),
    .any(pick_any), .single(pick_single)
  );

  assign start_ok    = start_i && (state_q == SEQ_IDLE);
  assign mask_empty  = (mask_i == '0);
  assign req_o       = (state_q == SEQ_RUN) && pick_any;
  assign accept      = req_o && ready_i;
  assign last_accept = accept && pick_single;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SEQ_IDLE;
      remain_q  <= '0;
      addr_q    <= '0;
      wbv_q     <= '0;
      load_q    <= 1'b0;
      user_q    <= 1'b0;
      wen_q     <= 1'b0;
      restore_q <= 1'b0;
    end else begin
      case (state_q)
        SEQ_IDLE: if (start_ok) begin
          state_q   <= mask_empty ? SEQ_FINISH : SEQ_RUN;
          remain_q  <= mask_i;
          addr_q    <= first_addr;
          wbv_q     <= final_base;
          load_q    <= load_i;
          user_q    <= sbit_i && !(load_i && mask_i[NREG-1]);
          wen_q     <= wback_i;
          restore_q <= load_i && sbit_i && mask_i[NREG-1];
        end
        SEQ_RUN: if (accept) begin
          remain_q <= remain_q & ~grant;
          addr_q   <= addr_q + ADDR_W'(WORD_BYTES);
          if (pick_single) state_q <= SEQ_FINISH;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy_o           = (state_q != SEQ_IDLE);
  assign done_o           = (state_q == SEQ_FINISH);
  assign req_addr_o       = addr_q;
  assign req_idx_o        = pick_idx;
  assign load_o           = busy_o && load_q;
  assign user_bank_o      = busy_o && user_q;
  assign wb_en_o          = done_o && wen_q;
  assign wb_value_o       = wbv_q;
  assign status_restore_o = done_o && restore_q;

  // R6: address steps by one word after an accepted, non-final access
  assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !last_accept) |=> (req_o && req_addr_o == $past(req_addr_o) + ADDR_W'(WORD_BYTES)));
  // R6: ascending register order
  assert_idx_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !last_accept) |=> (req_idx_o > $past(req_idx_o)));
  // R6: a stall holds the offered access
  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !ready_i) |=> (req_o && $stable(req_addr_o) && $stable(req_idx_o)));
  // R7: done follows the last acceptance and lasts one cycle
  assert_done_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    last_accept |=> (done_o && !req_o));
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));
  // R8: writeback only with done
  assert_wb_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en_o |-> done_o);
  // R9: empty mask finishes without any access
  assert_empty_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ok && mask_empty) |=> (done_o && !req_o));
  // R10: status restore only with done on a load
  assert_restore_R10: assert property (@(posedge clk) disable iff (!rst_n)
    status_restore_o |-> (done_o && load_o));
  // R12: captured writeback value does not move while busy
  assert_busy_ignore_R12: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(wb_value_o));
endmodule

// File: tb/lsm_addr_seq_test.sv
module lsm_addr_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] mask_i = '0;
  logic [31:0] base_i = '0;
  logic [1:0]  mode_i = '0;
  logic        load_i = 1'b0, sbit_i = 1'b0, wback_i = 1'b0, ready_i = 1'b0;
  logic        busy_o, req_o, load_o, user_bank_o, done_o, wb_en_o, status_restore_o;
  logic [31:0] req_addr_o, wb_value_o;
  logic [3:0]  req_idx_o;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  bit finished = 0;

  lsm_addr_seq uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mask_i(mask_i), .base_i(base_i),
    .mode_i(mode_i), .load_i(load_i), .sbit_i(sbit_i), .wback_i(wback_i),
    .ready_i(ready_i), .busy_o(busy_o), .req_o(req_o), .req_addr_o(req_addr_o),
    .req_idx_o(req_idx_o), .load_o(load_o), .user_bank_o(user_bank_o),
    .done_o(done_o), .wb_en_o(wb_en_o), .wb_value_o(wb_value_o),
    .status_restore_o(status_restore_o)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      miscompares++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      summary();
    end
  end

  task automatic run_one(input logic [15:0] lst, input logic [31:0] base, input logic [1:0] md,
                         input bit ld, input bit s, input bit w, input int v);
    int n;
    logic [31:0] low, first, wbv, a;
    string mtag;
    int k;
    n = $countones(lst);
    low = md[1] ? base - 32'(4 * n) : base;
    first = low + ((md[0] ^ md[1]) ? 32'd4 : 32'd0);
    wbv = md[1] ? base - 32'(4 * n) : base + 32'(4 * n);
    case (md)
      2'd0: mtag = "R2"; 2'd1: mtag = "R3"; 2'd2: mtag = "R4"; default: mtag = "R5";
    endcase
    @(negedge clk);
    start_i = 1; mask_i = lst; base_i = base; mode_i = md;
    load_i = ld; sbit_i = s; wback_i = w; ready_i = 0;
    @(negedge clk);
    start_i = 0; mask_i = ~lst; base_i = ~base;
    chk(busy_o == 1'b1, "R11 busy", busy_o, 1);
    chk(load_o == ld, "R11 load_o", load_o, ld);
    chk(user_bank_o == (s && !(ld && lst[15])), "R11 user_bank_o", user_bank_o,
        s && !(ld && lst[15]));
    k = 0;
    for (int i = 0; i < 16; i++) begin
      if (lst[i]) begin
        a = first + 32'(4 * k);
        chk(req_o == 1'b1, "R6 req", req_o, 1);
        chk(req_idx_o == 4'(i), "R6 idx", req_idx_o, i);
        chk(req_addr_o == a, (k == 0) ? mtag : "R6 addr", req_addr_o, a);
        if ((v + i) % 3 == 0) begin
          ready_i = 0;
          if ((v + i) % 2 == 0) begin start_i = 1; mode_i = ~md; end
          @(negedge clk);
          start_i = 0;
          chk(req_o == 1'b1 && req_idx_o == 4'(i) && req_addr_o == a, "R12 stall/start held",
              {req_idx_o, req_addr_o}, {4'(i), a});
        end
        ready_i = 1;
        @(negedge clk);
        ready_i = 0;
        k++;
      end
    end
    chk(done_o == 1'b1, (n == 0) ? "R9 done" : "R7 done", done_o, 1);
    chk(req_o == 1'b0, (n == 0) ? "R9 no req" : "R7 no extra req", req_o, 0);
    chk(wb_en_o == w, "R8 wb_en", wb_en_o, w);
    chk(wb_value_o == wbv, "R8 wb_value", wb_value_o, wbv);
    chk(status_restore_o == (ld && s && lst[15]), "R10 restore", status_restore_o,
        ld && s && lst[15]);
    start_i = 1; mask_i = 16'h00ff;
    @(negedge clk);
    start_i = 0;
    chk(done_o == 1'b0 && busy_o == 1'b0, "R7 R12 idle after done", {done_o, busy_o}, 0);
    chk(status_restore_o == 1'b0 && wb_en_o == 1'b0, "R10 restore low after", status_restore_o, 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk(busy_o == 0 && req_o == 0 && done_o == 0 && wb_en_o == 0 && status_restore_o == 0,
        "R1 reset", {busy_o, req_o, done_o, wb_en_o, status_restore_o}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(busy_o == 0 && req_o == 0, "R1 idle after reset", {busy_o, req_o}, 0);
    for (int v = 0; v < 320; v++) begin
      logic [15:0] lst;
      logic [31:0] base;
      case (v)
        0: lst = 16'h0000; 1: lst = 16'hffff; 2: lst = 16'h8000; 3: lst = 16'h0001;
        default: lst = 16'(v * 40503 + v * v * 13);
      endcase
      base = (v % 5 == 0) ? 32'(v * 4) : 32'h2000_0000 + 32'(v * 1028);
      for (int md = 0; md < 4; md++)
        run_one(lst, base, 2'(md), v[0], v[1] ^ v[3], v[2], v + md);
    end
    summary();
  end
endmodule